// File: doc/BRIEF.md
# Frame Header Format Decoder

This block runs once at the start of every display frame. It takes the first 16-bit word of the frame buffer, which carries a three-bit colour-depth code in bits 14:12. It also takes the frame's configured width and height, the palette-load mode, the partial-panel settings and the number of bytes in the source buffer. From these it works out how the frame is laid out: bits per pixel, where pixel data starts past the palette header, which lines to fetch, and how many bytes one line occupies. It also checks that the whole image fits in the buffer.

Three cycles after it accepts a frame-start strobe, the block gives exactly one of three one-cycle verdicts. The first is a go pulse to the line fetcher, with the layout fields valid. The second is a skip pulse, for a frame that must not be processed. The third is a sync-error pulse, for a frame that would overrun its buffer; the surrounding controller clears its enable on it.

The sequencer has four states. IDLE waits for a strobe. DECODE resolves depth, header length and line window. SIZE computes stride and the overrun test. ISSUE emits the verdict. The transitions are IDLE→DECODE on `frame_start`, then DECODE→SIZE, SIZE→ISSUE and ISSUE→IDLE, each taken unconditionally.

Top module: `fmt_decoder`

## Requirements
- R1: Depth code (first word bits 14:12) maps to `pix_bits`: code 1 gives 2, code 2 gives 4, code 3 gives 8, codes 4 to 7 give 16.
- R2: Depth code 0 produces `frame_skip` and no `fetch_go`.
- R3: `data_offset` is 0 when the load mode is 2. In any other mode it is 512 for codes 3 to 7 and 32 for codes 1 and 2.
- R4: Load mode 1 produces `frame_skip` for every depth code and buffer size, never `fetch_go` or `sync_err`.
- R5: With need = `data_offset` + width×height×bpp/8, need greater than `buf_bytes`+2 gives `sync_err` and no `fetch_go`. Need equal to `buf_bytes`+2 is accepted.
- R6: `stride` equals width×bpp/8, with the fraction dropped.
- R7: With `sub_en`=1 and `sub_first`=1, `first_line` equals `sub_line`. `line_count` equals height−`sub_line` when `sub_line` is below height, and 0 otherwise.
- R8: With `sub_en`=1 and `sub_first`=0, `first_line` is 0 and `line_count` equals `sub_line`. With `sub_en`=0, `first_line` is 0 and `line_count` equals height.
- R9: Each accepted strobe yields exactly one one-cycle pulse among `fetch_go`, `frame_skip` and `sync_err`, three clock edges after the edge that samples it. Strobes seen while a frame is in progress are ignored. Inputs are captured at acceptance.
- R10: During and after reset, with no strobe, all three pulses are low.
- R11: The size test stays exact for a 1024×1024 frame at 16 bpp: need 2,097,152 passes against `buf_bytes` 2,097,150 and fails against 2,097,149.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame-start strobe, accepted in IDLE |
| pal_word | input | 16 | First word of the frame buffer; bits 14:12 hold the depth code |
| width_px | input | PIX_W | Frame width in pixels |
| height_px | input | PIX_W | Frame height in lines |
| load_mode | input | 2 | Palette-load mode: 1 suppresses, 2 means no header |
| sub_en | input | 1 | Partial-panel enable |
| sub_first | input | 1 | Partial-panel line number is a start line (1) or a line count (0) |
| sub_line | input | SUB_W | Partial-panel line number |
| buf_bytes | input | BUF_W | Source buffer length in bytes |
| fetch_go | output | 1 | One-cycle start request to the line fetcher |
| frame_skip | output | 1 | One-cycle pulse: frame not processed |
| sync_err | output | 1 | One-cycle pulse: buffer overrun, controller must disable |
| pix_bits | output | 5 | Bits per pixel (0 when unsupported) |
| data_offset | output | 10 | Byte offset of pixel data |
| stride | output | PIX_W+1 | Bytes per line |
| first_line | output | PIX_W | First line to fetch |
| line_count | output | PIX_W | Number of lines to fetch |

## Verification
On every cycle, the assertions check the outcome structure. At most one verdict may be active, and none lasts two cycles. Every verdict follows the SIZE state, and a go never occurs in suppress mode. A go also carries a power-of-two depth, a zero offset when there is no header, and the full window when partial panel is off. The arithmetic is shown only by the bench's scenarios, which compare against an integer model: exact stride truncation, the overrun boundary at need equal to buffer plus two, the large-frame case, the clipped start-line window, and the rejection of a strobe repeated while busy.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_SIZE,
        ST_ISSUE
    } fmt_state_t;

    localparam int          OFF_W      = 10;
    localparam int          HDR_SMALL  = 32;
    localparam int          HDR_LARGE  = 512;
    localparam logic [1:0]  LM_SUPPRESS = 2'd1;
    localparam logic [1:0]  LM_NO_HDR   = 2'd2;
endpackage

// File: rtl/fmt_depth_decode.sv
module fmt_depth_decode
    import fmt_pkg::*;
(
    input  logic [2:0]       code,
    input  logic [1:0]       mode,
    output logic [2:0]       lg_bpp,
    output logic [OFF_W-1:0] offset
);
    always_comb begin
        unique case (code)
            3'd0:    lg_bpp = 3'd0;
            3'd1:    lg_bpp = 3'd1;
            3'd2:    lg_bpp = 3'd2;
            3'd3:    lg_bpp = 3'd3;
            default: lg_bpp = 3'd4;
        endcase
    end

    always_comb begin
        if (mode == LM_NO_HDR)
            offset = '0;
        else if (code >= 3'd3)
            offset = OFF_W'(HDR_LARGE);
        else
            offset = OFF_W'(HDR_SMALL);
    end
endmodule

// File: rtl/fmt_line_window.sv
module fmt_line_window #(
    parameter int PIX_W = 11,
    parameter int SUB_W = 10
) (
    input  logic [PIX_W-1:0] height,
    input  logic             sub_en,
    input  logic             sub_first,
    input  logic [SUB_W-1:0] sub_line,
    output logic [PIX_W-1:0] first,
    output logic [PIX_W-1:0] count
);
    logic [PIX_W-1:0] n;
    assign n = PIX_W'(sub_line);

    always_comb begin
        first = '0;
        count = height;
        if (sub_en) begin
            if (sub_first) begin
                first = n;
                count = (n < height) ? (height - n) : '0;
            end else begin
                count = n;
            end
        end
    end
endmodule

// File: rtl/fmt_extent.sv
module fmt_extent
    import fmt_pkg::*;
#(
    parameter int PIX_W = 11,
    parameter int BUF_W = 24
) (
    input  logic [PIX_W-1:0] width,
    input  logic [PIX_W-1:0] height,
    input  logic [2:0]       lg_bpp,
    input  logic [OFF_W-1:0] offset,
    input  logic [BUF_W-1:0] buf_bytes,
    output logic [PIX_W:0]   stride,
    output logic             overrun
);
    localparam int NEED_W = 2 * PIX_W + 4;
    localparam int CMP_W  = ((NEED_W > BUF_W) ? NEED_W : BUF_W) + 2;
    localparam int ROW_W  = PIX_W + 5;

    logic [CMP_W-1:0] area, need, limit;
    logic [ROW_W-1:0] row_bits;

    assign area     = CMP_W'(width) * CMP_W'(height);
    assign need     = ((area << lg_bpp) >> 3) + CMP_W'(offset);
    assign limit    = CMP_W'(buf_bytes) + CMP_W'(2);
    assign overrun  = need > limit;

    assign row_bits = ROW_W'(width) << lg_bpp;
    assign stride   = (PIX_W+1)'(row_bits >> 3);
endmodule

// File: rtl/fmt_decoder.sv
module fmt_decoder
    import fmt_pkg::*;
#(
    parameter int PIX_W = 11,
    parameter int SUB_W = 10,
    parameter int BUF_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic [15:0]        pal_word,
    input  logic [PIX_W-1:0]   width_px,
    input  logic [PIX_W-1:0]   height_px,
    input  logic [1:0]         load_mode,
    input  logic               sub_en,
    input  logic               sub_first,
    input  logic [SUB_W-1:0]   sub_line,
    input  logic [BUF_W-1:0]   buf_bytes,
    output logic               fetch_go,
    output logic               frame_skip,
    output logic               sync_err,
    output logic [4:0]         pix_bits,
    output logic [OFF_W-1:0]   data_offset,
    output logic [PIX_W:0]     stride,
    output logic [PIX_W-1:0]   first_line,
    output logic [PIX_W-1:0]   line_count
);
    fmt_state_t state, state_d;

    logic unused_word_bits;
    assign unused_word_bits = ^{pal_word[15], pal_word[11:0]};

    // captured frame description
    logic [2:0]       code_q;
    logic [PIX_W-1:0] w_q, h_q;
    logic [1:0]       mode_q;
    logic             sub_en_q, sub_first_q;
    logic [SUB_W-1:0] sub_line_q;
    logic [BUF_W-1:0] buf_q;

    // decoded layout
    logic [2:0]       lg_q, lg_d;
    logic [OFF_W-1:0] off_q, off_d;
    logic [PIX_W-1:0] first_q, first_d, count_q, count_d;
    logic [PIX_W:0]   stride_q, stride_d;
    logic             overrun_q, overrun_d;
    logic             is_skip;

    fmt_depth_decode u_depth (
        .code   (code_q),
        .mode   (mode_q),
        .lg_bpp (lg_d),
        .offset (off_d)
    );

    fmt_line_window #(.PIX_W(PIX_W), .SUB_W(SUB_W)) u_window (
        .height    (h_q),
        .sub_en    (sub_en_q),
        .sub_first (sub_first_q),
        .sub_line  (sub_line_q),
        .first     (first_d),
        .count     (count_d)
    );

    fmt_extent #(.PIX_W(PIX_W), .BUF_W(BUF_W)) u_extent (
        .width     (w_q),
        .height    (h_q),
        .lg_bpp    (lg_q),
        .offset    (off_q),
        .buf_bytes (buf_q),
        .stride    (stride_d),
        .overrun   (overrun_d)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:   if (frame_start) state_d = ST_DECODE;
            ST_DECODE: state_d = ST_SIZE;
            ST_SIZE:   state_d = ST_ISSUE;
            ST_ISSUE:  state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0; w_q <= '0; h_q <= '0; mode_q <= '0;
            sub_en_q <= 1'b0; sub_first_q <= 1'b0; sub_line_q <= '0; buf_q <= '0;
            lg_q <= '0; off_q <= '0; first_q <= '0; count_q <= '0;
            stride_q <= '0; overrun_q <= 1'b0;
        end else begin
            if (state == ST_IDLE && frame_start) begin
                code_q      <= pal_word[14:12];
                w_q         <= width_px;
                h_q         <= height_px;
                mode_q      <= load_mode;
                sub_en_q    <= sub_en;
                sub_first_q <= sub_first;
                sub_line_q  <= sub_line;
                buf_q       <= buf_bytes;
            end
            if (state == ST_DECODE) begin
                lg_q    <= lg_d;
                off_q   <= off_d;
                first_q <= first_d;
                count_q <= count_d;
            end
            if (state == ST_SIZE) begin
                stride_q  <= stride_d;
                overrun_q <= overrun_d;
            end
        end
    end

    // outputs
    always_comb begin
        is_skip     = (mode_q == LM_SUPPRESS) || (lg_q == 3'd0);
        fetch_go    = (state == ST_ISSUE) && !is_skip && !overrun_q;
        frame_skip  = (state == ST_ISSUE) && is_skip;
        sync_err    = (state == ST_ISSUE) && !is_skip && overrun_q;
        pix_bits    = (lg_q == 3'd0) ? 5'd0 : (5'd1 << lg_q);
        data_offset = off_q;
        stride      = stride_q;
        first_line  = first_q;
        line_count  = count_q;
    end
endmodule

// File: rtl/fmt_decoder_chk.sv
module fmt_decoder_chk
    import fmt_pkg::*;
#(
    parameter int PIX_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_go,
    input logic             frame_skip,
    input logic             sync_err,
    input logic [4:0]       pix_bits,
    input logic [OFF_W-1:0] data_offset,
    input logic [PIX_W-1:0] first_line,
    input logic [PIX_W-1:0] line_count,
    input fmt_state_t       state,
    input logic [1:0]       mode_q,
    input logic [PIX_W-1:0] h_q,
    input logic             sub_en_q
);
    logic any_verdict;
    assign any_verdict = fetch_go | frame_skip | sync_err;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_go, frame_skip, sync_err})); // R9
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        any_verdict |=> !any_verdict); // R9
    AST_AFTER_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        any_verdict |-> $past(state) == ST_SIZE); // R9
    AST_BPP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |-> ($onehot(pix_bits) && pix_bits >= 5'd2)); // R1
    AST_NO_HDR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_go && mode_q == LM_NO_HDR) |-> data_offset == '0); // R3
    AST_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        any_verdict && mode_q == LM_SUPPRESS |-> frame_skip); // R4
    AST_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_go && !sub_en_q) |-> (first_line == '0 && line_count == h_q)); // R8
endmodule

bind fmt_decoder fmt_decoder_chk #(.PIX_W(PIX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_go    (fetch_go),
    .frame_skip  (frame_skip),
    .sync_err    (sync_err),
    .pix_bits    (pix_bits),
    .data_offset (data_offset),
    .first_line  (first_line),
    .line_count  (line_count),
    .state       (state),
    .mode_q      (mode_q),
    .h_q         (h_q),
    .sub_en_q    (sub_en_q)
);

// File: tb/fmt_decoder_tb.sv
module fmt_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_W = 11;
    localparam int SUB_W = 10;
    localparam int BUF_W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic [15:0] pal_word = '0;
    logic [PIX_W-1:0] width_px = '0, height_px = '0;
    logic [1:0] load_mode = '0;
    logic sub_en = 1'b0, sub_first = 1'b0;
    logic [SUB_W-1:0] sub_line = '0;
    logic [BUF_W-1:0] buf_bytes = '0;
    logic fetch_go, frame_skip, sync_err;
    logic [4:0] pix_bits;
    logic [9:0] data_offset;
    logic [PIX_W:0] stride;
    logic [PIX_W-1:0] first_line, line_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fmt_decoder #(.PIX_W(PIX_W), .SUB_W(SUB_W), .BUF_W(BUF_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pal_word(pal_word),
        .width_px(width_px), .height_px(height_px), .load_mode(load_mode),
        .sub_en(sub_en), .sub_first(sub_first), .sub_line(sub_line),
        .buf_bytes(buf_bytes), .fetch_go(fetch_go), .frame_skip(frame_skip),
        .sync_err(sync_err), .pix_bits(pix_bits), .data_offset(data_offset),
        .stride(stride), .first_line(first_line), .line_count(line_count)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // verdict encoding for compare: 0 none, 1 go, 2 skip, 3 error
    function automatic int verdict_now();
        return fetch_go ? 1 : frame_skip ? 2 : sync_err ? 3 : 0;
    endfunction

    task automatic run_frame(input int code, input int mode, input int w, input int h,
                             input bit se, input bit sf, input int sl, input longint bufb,
                             input bit hold, input string tag);
        int lg, bpp, off, exp_v, exp_first, exp_count;
        longint need;
        lg   = (code == 0) ? 0 : (code >= 4) ? 4 : code;
        bpp  = 1 << lg;
        off  = (mode == 2) ? 0 : (code >= 3) ? 512 : 32;
        need = off + (longint'(w) * h * bpp) / 8;
        if (mode == 1 || code == 0) exp_v = 2;
        else if (need > bufb + 2)   exp_v = 3;
        else                        exp_v = 1;
        exp_first = 0; exp_count = h;
        if (se && sf) begin exp_first = sl; exp_count = (sl < h) ? h - sl : 0; end
        else if (se)  begin exp_count = sl; end

        @(negedge clk);
        pal_word = 16'(code << 12) | 16'h8abc;
        load_mode = 2'(mode); width_px = PIX_W'(w); height_px = PIX_W'(h);
        sub_en = se; sub_first = sf; sub_line = SUB_W'(sl); buf_bytes = BUF_W'(bufb);
        frame_start = 1'b1;
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk);
            if (c == 1) begin
                // inputs are captured at acceptance; scramble them now (R9)
                frame_start = hold; pal_word = 16'h0000; load_mode = 2'd1;
                width_px = '1; height_px = '1; buf_bytes = '0; sub_en = ~se;
            end else begin
                frame_start = 1'b0;
            end
            check({tag, " R9 verdict"}, verdict_now(), (c == 3) ? exp_v : 0);
            if (c == 3 && exp_v == 1) begin
                check({tag, " R1 pix_bits"}, pix_bits, bpp);
                check({tag, " R3 data_offset"}, data_offset, off);
                check({tag, " R6 stride"}, stride, (w * bpp) / 8);
                check({tag, " R7 first_line"}, first_line, exp_first);
                check({tag, " R8 line_count"}, line_count, exp_count);
            end
        end
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            check("R10 reset verdict", verdict_now(), 0);
        end
        rst_n = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check("R10 idle verdict", verdict_now(), 0);
        end
        // R1 R3 R6 depth codes and header lengths
        run_frame(1, 0, 100, 10, 0, 0, 0, 100000, 0, "code1");
        run_frame(1, 0, 101, 10, 0, 0, 0, 100000, 0, "code1 trunc R6");
        run_frame(2, 3, 30, 8, 0, 0, 0, 100000, 0, "code2");
        run_frame(3, 0, 64, 4, 0, 0, 0, 100000, 0, "code3");
        run_frame(5, 2, 40, 4, 0, 0, 0, 100000, 0, "code5 nohdr");
        run_frame(7, 0, 12, 3, 0, 0, 0, 100000, 0, "code7");
        // R2 code 0, R4 suppress mode with a buffer that would overrun
        run_frame(0, 0, 10, 10, 0, 0, 0, 100000, 0, "R2 code0");
        run_frame(3, 1, 500, 500, 0, 0, 0, 0, 0, "R4 suppress");
        // R5 boundary: need = 512 + 200 = 712
        run_frame(4, 0, 10, 10, 0, 0, 0, 709, 0, "R5 over");
        run_frame(4, 0, 10, 10, 0, 0, 0, 710, 0, "R5 equal");
        // R11 full size frame at 16 bpp: need = 2097152
        run_frame(7, 2, 1024, 1024, 0, 0, 0, 2097150, 0, "R11 fits");
        run_frame(7, 2, 1024, 1024, 0, 0, 0, 2097149, 0, "R11 over");
        // R7 start-line window, R8 count window
        run_frame(3, 0, 16, 20, 1, 1, 5, 100000, 0, "R7 start");
        run_frame(3, 0, 16, 20, 1, 1, 25, 100000, 0, "R7 clip");
        run_frame(3, 0, 16, 20, 1, 0, 7, 100000, 0, "R8 count");
        // R9 strobe held while busy is ignored
        run_frame(2, 0, 8, 8, 0, 0, 0, 100000, 1, "R9 busy");
        repeat (3) begin
            @(negedge clk);
            check("R9 no second verdict", verdict_now(), 0);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule